// File: doc/BRIEF.md
# Cartridge ROM Block Transfer Controller

This controller sits on the host side of a game cartridge slot. Software first loads an eight-byte command into four 16-bit command registers. It then writes a control word that selects the block size, the byte rate, an extra start-up delay and the interrupt enable, and sets the start bit. For a data-read command the controller waits out the cartridge's start-up latency and then delivers the reply one 32-bit word at a time. Each word is fetched from the cartridge data source at a rising address. The controller raises a word-ready flag and a one-cycle DMA request for each word, and it signals the end of the block with an interrupt pulse. It can also issue a pulse that disables a non-repeating DMA channel.

Pacing follows the host. After the first word, the next word is only started once the host has read the current one through the data port, and it then takes four byte times to arrive. A byte time is 5 clocks, or 8 clocks with the slow-rate bit set, and it is doubled when the secondary processor does not own the slot. Read addresses below the protected floor are folded back above it. A chip-identification command answers at once with a fixed word.

The cartridge data source must present the word for `rom_addr` combinationally on `rom_data`.

Top module: `cart_xfer_ctrl`

## Requirements
- R1: `cmd_sel` value h writes `cmd_wdata[7:0]` to command byte 2h and `cmd_wdata[15:8]` to byte 2h+1. Byte 0 is the opcode. For opcode 0xB7 the read address is bytes 1..4 with byte 1 as the most significant.
- R2: A requested read address below 0x8000 is replaced by 0x8000 plus the requested address's low 9 bits. Any other address is used unchanged.
- R3: `cfg_blk` code 0 means no data, code 7 means one 4-byte word, and code n (1..6) means 2^(BASE_LOG2+n) bytes. `busy` falls after the host has read exactly that many bytes.
- R4: The first word of a read sets `word_ready` exactly (cfg_dly+12)·c rising edges after the start edge. Here c is 5, or 8 when `cfg_slow`=1, and c is doubled when `owner_sec`=0.
- R5: Every later word sets `word_ready` exactly 4·c edges after the edge that accepted the host read of the previous word. While no read occurs, `word_ready` and `data_out` hold.
- R6: Word k of a block carries `rom_data` for address A+4k, where A is the effective start address.
- R7: A `data_rd` while `word_ready` is 1 clears `word_ready` at that edge. If this was the last word, `busy` also clears at that edge.
- R8: Each delivered data word pulses `dma_req` for one cycle, together with `word_ready` rising, when `dma_en`=1. It never pulses when `dma_en`=0.
- R9: With the last word, `irq` pulses when the latched interrupt enable is set. `dma_off` pulses when `dma_en`=1 and `dma_repeat`=0.
- R10: Opcode 0xB8 puts CHIP_ID on `data_out`, with `word_ready`=1 and `busy`=1, at the start edge. No DMA request or interrupt is issued, and one host read ends the transfer.
- R11: A start with any other opcode, or with 0xB7 and block code 0, leaves `busy` and `word_ready` low and produces no word.
- R12: A start while busy abandons the pending word and restarts timing from the new start edge. This holds even when it lands on the edge at which the pending word would have completed: that word, and its DMA request, never appear.
- R13: After reset `busy`, `word_ready`, `dma_req`, `dma_off`, `irq` and `data_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Command register write strobe |
| cmd_sel | input | 2 | Command halfword select |
| cmd_wdata | input | 16 | Command halfword data, low byte first |
| cfg_we | input | 1 | Control word write strobe |
| cfg_start | input | 1 | Start bit of the control word |
| cfg_blk | input | 3 | Block size code |
| cfg_slow | input | 1 | Slow byte rate select |
| cfg_dly | input | DLY_W | Extra start-up delay in byte times |
| cfg_irq_en | input | 1 | End-of-block interrupt enable |
| owner_sec | input | 1 | Secondary processor owns the slot |
| dma_en | input | 1 | A slot-timed DMA channel is enabled |
| dma_repeat | input | 1 | That DMA channel repeats |
| data_rd | input | 1 | Host read of the data port |
| rom_addr | output | 32 | Cartridge word address |
| rom_data | input | 32 | Cartridge word for rom_addr |
| data_out | output | 32 | Current reply word |
| word_ready | output | 1 | A reply word is waiting |
| busy | output | 1 | Transfer in progress |
| dma_req | output | 1 | One-cycle DMA request per word |
| dma_off | output | 1 | One-cycle pulse to clear a non-repeating DMA enable |
| irq | output | 1 | One-cycle end-of-block interrupt |

## Verification
Two events can fall on the same clock edge: a new start write, and the expiry of the byte-time countdown for the pending word. The bench counts the cycles of the first-word wait and places the second start write on exactly the edge where that word would complete. It then checks that neither `word_ready` nor `dma_req` appears at that edge, that `busy` stays high, and that the next word arrives a full new start-up delay later, with the interrupt and DMA pulses matched to that restarted block.

// File: rtl/cart_xfer_pkg.sv
package cart_xfer_pkg;
  localparam logic [7:0] OP_DATA_READ = 8'hB7;
  localparam logic [7:0] OP_CHIP_ID   = 8'hB8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_READY
  } xfer_state_t;
endpackage

// File: rtl/cart_cmd_regs.sv
module cart_cmd_regs #(
  parameter logic [31:0] SECURE_LIMIT = 32'h0000_8000,
  parameter int unsigned WRAP_BITS    = 9
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_we,
  input  logic [1:0]  cmd_sel,
  input  logic [15:0] cmd_wdata,
  output logic [7:0]  opcode_o,
  output logic [31:0] addr_o
);
  localparam logic [31:0] WRAP_MASK = (32'd1 << WRAP_BITS) - 32'd1;
  localparam int unsigned HELD = 5;   // opcode plus four address bytes

  logic [7:0] cb_q [HELD];
  logic [31:0] raw_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < HELD; i++) cb_q[i] <= '0;
    end else if (cmd_we) begin
      for (int h = 0; h < 3; h++) begin
        if (cmd_sel == 2'(h)) begin
          cb_q[2*h] <= cmd_wdata[7:0];
          if (2*h + 1 < HELD) cb_q[2*h+1] <= cmd_wdata[15:8];
        end
      end
    end
  end

  always_comb begin
    opcode_o = cb_q[0];
    raw_addr = {cb_q[1], cb_q[2], cb_q[3], cb_q[4]};
    if (raw_addr < SECURE_LIMIT) addr_o = SECURE_LIMIT + (raw_addr & WRAP_MASK);
    else                         addr_o = raw_addr;
  end
endmodule

// File: rtl/cart_pace_timer.sv
module cart_pace_timer #(
  parameter int unsigned FAST_CYC = 5,
  parameter int unsigned SLOW_CYC = 8,
  parameter int unsigned BYTES_W  = 5,
  parameter int unsigned CNT_W    = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic               cfg_slow,
  input  logic               owner_i,
  input  logic               load_i,
  input  logic [BYTES_W-1:0] bytes_i,
  output logic               expire_o
);
  logic             slow_q;
  logic             rate_slow;
  logic [CNT_W-1:0] cost;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)         slow_q <= 1'b0;
    else if (cfg_we) slow_q <= cfg_slow;
  end

  always_comb begin
    rate_slow = cfg_we ? cfg_slow : slow_q;
    cost = rate_slow ? CNT_W'(SLOW_CYC) : CNT_W'(FAST_CYC);
    if (!owner_i) cost = cost << 1;
  end

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load_i)        cnt_q <= CNT_W'(bytes_i) * cost;
    else if (cnt_q != '0)   cnt_q <= cnt_q - CNT_W'(1);
  end

  assign expire_o = (cnt_q == CNT_W'(1));

  // R4
  expire_settle_chk: assert property (@(posedge clk) disable iff (rst)
    (expire_o && !load_i) |=> (cnt_q == '0));
endmodule

// File: rtl/cart_xfer_seq.sv
module cart_xfer_seq
  import cart_xfer_pkg::*;
#(
  parameter int unsigned BASE_LOG2 = 8,
  parameter int unsigned DLY_W     = 4,
  parameter int unsigned DLY_ADD   = 12,
  parameter int unsigned BYTES_W   = 5,
  parameter logic [31:0] CHIP_ID   = 32'h0000_0FC2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [2:0]         blk_i,
  input  logic [DLY_W-1:0]   dly_i,
  input  logic               irq_en_i,
  input  logic [7:0]         opcode_i,
  input  logic [31:0]        addr_i,
  input  logic               rd_i,
  input  logic               expire_i,
  input  logic [31:0]        rom_data_i,
  input  logic               dma_en_i,
  input  logic               dma_rep_i,
  output logic               timer_load_o,
  output logic [BYTES_W-1:0] timer_bytes_o,
  output logic [31:0]        rom_addr_o,
  output logic [31:0]        data_o,
  output logic               ready_o,
  output logic               busy_o,
  output logic               dma_req_o,
  output logic               dma_off_o,
  output logic               irq_o
);
  localparam int unsigned REM_W = BASE_LOG2 + 7;

  xfer_state_t      state_q;
  logic [REM_W-1:0] rem_q;
  logic [REM_W-1:0] size_bytes;
  logic [31:0]      addr_q;
  logic             irq_en_q;
  logic             start_read;
  logic             read_accept;

  function automatic logic [REM_W-1:0] decode_size(input logic [2:0] code);
    if (code == 3'd0)      return '0;
    else if (code == 3'd7) return REM_W'(4);
    else                   return REM_W'(1) << (BASE_LOG2 + 32'(code));
  endfunction

  always_comb begin
    size_bytes  = decode_size(blk_i);
    start_read  = start_i && (opcode_i == OP_DATA_READ) && (size_bytes != '0);
    read_accept = (state_q == ST_READY) && rd_i;
    timer_load_o = start_i || (read_accept && rem_q != '0);
    if (start_i)
      timer_bytes_o = start_read ? (BYTES_W'(dly_i) + BYTES_W'(DLY_ADD)) : '0;
    else
      timer_bytes_o = BYTES_W'(4);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      rem_q     <= '0;
      addr_q    <= '0;
      irq_en_q  <= 1'b0;
      data_o    <= '0;
      ready_o   <= 1'b0;
      busy_o    <= 1'b0;
      dma_req_o <= 1'b0;
      dma_off_o <= 1'b0;
      irq_o     <= 1'b0;
    end else begin
      dma_req_o <= 1'b0;
      dma_off_o <= 1'b0;
      irq_o     <= 1'b0;
      if (start_i) begin
        irq_en_q <= irq_en_i;
        ready_o  <= 1'b0;
        if (start_read) begin
          state_q <= ST_WAIT;
          busy_o  <= 1'b1;
          rem_q   <= size_bytes;
          addr_q  <= addr_i;
        end else if (opcode_i == OP_CHIP_ID) begin
          state_q <= ST_READY;
          busy_o  <= 1'b1;
          ready_o <= 1'b1;
          data_o  <= CHIP_ID;
          rem_q   <= '0;
        end else begin
          state_q <= ST_IDLE;
          busy_o  <= 1'b0;
          rem_q   <= '0;
        end
      end else begin
        case (state_q)
          ST_WAIT: begin
            if (expire_i) begin
              data_o    <= rom_data_i;
              ready_o   <= 1'b1;
              rem_q     <= rem_q - REM_W'(4);
              addr_q    <= addr_q + 32'd4;
              state_q   <= ST_READY;
              dma_req_o <= dma_en_i;
              if (rem_q == REM_W'(4)) begin
                irq_o     <= irq_en_q;
                dma_off_o <= dma_en_i && !dma_rep_i;
              end
            end
          end
          ST_READY: begin
            if (rd_i) begin
              ready_o <= 1'b0;
              if (rem_q != '0) state_q <= ST_WAIT;
              else begin
                state_q <= ST_IDLE;
                busy_o  <= 1'b0;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign rom_addr_o = addr_q;

  // R7
  ready_within_busy_chk: assert property (@(posedge clk) disable iff (rst)
    ready_o |-> busy_o);
  // R7
  last_read_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (read_accept && rem_q == '0 && !start_i) |=> !busy_o);
  // R5
  hold_until_read_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_READY && !rd_i && !start_i) |=> (ready_o && $stable(data_o)));
  // R9
  irq_last_word_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (ready_o && rem_q == '0));
  // R9
  dma_off_with_req_chk: assert property (@(posedge clk) disable iff (rst)
    dma_off_o |-> dma_req_o);
endmodule

// File: rtl/cart_xfer_ctrl.sv
module cart_xfer_ctrl #(
  parameter int unsigned BASE_LOG2    = 8,
  parameter int unsigned DLY_W        = 4,
  parameter int unsigned DLY_ADD      = 12,
  parameter int unsigned FAST_CYC     = 5,
  parameter int unsigned SLOW_CYC     = 8,
  parameter logic [31:0] CHIP_ID      = 32'h0000_0FC2,
  parameter logic [31:0] SECURE_LIMIT = 32'h0000_8000,
  parameter int unsigned WRAP_BITS    = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_we,
  input  logic [1:0]       cmd_sel,
  input  logic [15:0]      cmd_wdata,
  input  logic             cfg_we,
  input  logic             cfg_start,
  input  logic [2:0]       cfg_blk,
  input  logic             cfg_slow,
  input  logic [DLY_W-1:0] cfg_dly,
  input  logic             cfg_irq_en,
  input  logic             owner_sec,
  input  logic             dma_en,
  input  logic             dma_repeat,
  input  logic             data_rd,
  output logic [31:0]      rom_addr,
  input  logic [31:0]      rom_data,
  output logic [31:0]      data_out,
  output logic             word_ready,
  output logic             busy,
  output logic             dma_req,
  output logic             dma_off,
  output logic             irq
);
  localparam int unsigned MAX_BYTES = (1 << DLY_W) + DLY_ADD;
  localparam int unsigned BYTES_W   = $clog2(MAX_BYTES + 1);
  localparam int unsigned CNT_W     = $clog2(MAX_BYTES * SLOW_CYC * 2 + 1);

  logic [7:0]         opcode;
  logic [31:0]        eff_addr;
  logic               start;
  logic               t_load;
  logic [BYTES_W-1:0] t_bytes;
  logic               t_expire;

  assign start = cfg_we && cfg_start;

  cart_cmd_regs #(
    .SECURE_LIMIT(SECURE_LIMIT),
    .WRAP_BITS   (WRAP_BITS)
  ) u_cmd (
    .clk      (clk),
    .rst      (rst),
    .cmd_we   (cmd_we),
    .cmd_sel  (cmd_sel),
    .cmd_wdata(cmd_wdata),
    .opcode_o (opcode),
    .addr_o   (eff_addr)
  );

  cart_pace_timer #(
    .FAST_CYC(FAST_CYC),
    .SLOW_CYC(SLOW_CYC),
    .BYTES_W (BYTES_W),
    .CNT_W   (CNT_W)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .cfg_we  (cfg_we),
    .cfg_slow(cfg_slow),
    .owner_i (owner_sec),
    .load_i  (t_load),
    .bytes_i (t_bytes),
    .expire_o(t_expire)
  );

  cart_xfer_seq #(
    .BASE_LOG2(BASE_LOG2),
    .DLY_W    (DLY_W),
    .DLY_ADD  (DLY_ADD),
    .BYTES_W  (BYTES_W),
    .CHIP_ID  (CHIP_ID)
  ) u_seq (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start),
    .blk_i        (cfg_blk),
    .dly_i        (cfg_dly),
    .irq_en_i     (cfg_irq_en),
    .opcode_i     (opcode),
    .addr_i       (eff_addr),
    .rd_i         (data_rd),
    .expire_i     (t_expire),
    .rom_data_i   (rom_data),
    .dma_en_i     (dma_en),
    .dma_rep_i    (dma_repeat),
    .timer_load_o (t_load),
    .timer_bytes_o(t_bytes),
    .rom_addr_o   (rom_addr),
    .data_o       (data_out),
    .ready_o      (word_ready),
    .busy_o       (busy),
    .dma_req_o    (dma_req),
    .dma_off_o    (dma_off),
    .irq_o        (irq)
  );
endmodule

// File: tb/cart_xfer_ctrl_bench.sv
`timescale 1ns/1ps
module cart_xfer_ctrl_bench;
  localparam int unsigned BL2 = 2;
  localparam logic [31:0] CID = 32'h00C2_3F01;
  localparam logic [31:0] SALT = 32'hC3A5_5A3C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_we = 1'b0;
  logic [1:0]  cmd_sel = '0;
  logic [15:0] cmd_wdata = '0;
  logic        cfg_we = 1'b0, cfg_start = 1'b0, cfg_slow = 1'b0, cfg_irq_en = 1'b0;
  logic [2:0]  cfg_blk = '0;
  logic [3:0]  cfg_dly = '0;
  logic        owner_sec = 1'b1, dma_en = 1'b0, dma_repeat = 1'b0, data_rd = 1'b0;
  logic [31:0] rom_addr, rom_data, data_out;
  logic        word_ready, busy, dma_req, dma_off, irq;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;
  assign rom_data = rom_addr ^ SALT;

  cart_xfer_ctrl #(.BASE_LOG2(BL2), .CHIP_ID(CID)) u_cart_xfer_ctrl (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_sel(cmd_sel), .cmd_wdata(cmd_wdata),
    .cfg_we(cfg_we), .cfg_start(cfg_start), .cfg_blk(cfg_blk), .cfg_slow(cfg_slow),
    .cfg_dly(cfg_dly), .cfg_irq_en(cfg_irq_en), .owner_sec(owner_sec), .dma_en(dma_en),
    .dma_repeat(dma_repeat), .data_rd(data_rd), .rom_addr(rom_addr), .rom_data(rom_data),
    .data_out(data_out), .word_ready(word_ready), .busy(busy), .dma_req(dma_req),
    .dma_off(dma_off), .irq(irq));

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] eff_of(input logic [31:0] a);
    return (a < 32'h8000) ? 32'h8000 + (a & 32'h1FF) : a;
  endfunction

  function automatic int cost_of(input bit slow, input bit own);
    return (slow ? 8 : 5) * (own ? 1 : 2);
  endfunction

  task automatic load_cmd(input logic [7:0] op, input logic [31:0] a);
    logic [7:0] cb [8];
    cb[0] = op; cb[1] = a[31:24]; cb[2] = a[23:16]; cb[3] = a[15:8]; cb[4] = a[7:0];
    cb[5] = 8'h5A; cb[6] = 8'hA5; cb[7] = 8'h3C;
    for (int h = 0; h < 4; h++) begin
      @(negedge clk);
      cmd_we = 1'b1; cmd_sel = 2'(h); cmd_wdata = {cb[2*h+1], cb[2*h]};
    end
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  // drive a start write; returns just after the start edge
  task automatic kick(input logic [2:0] code, input bit slow, input logic [3:0] dly,
                      input bit ien, input bit already_low);
    if (!already_low) @(negedge clk);
    cfg_we = 1'b1; cfg_start = 1'b1; cfg_blk = code; cfg_slow = slow;
    cfg_dly = dly; cfg_irq_en = ien;
    @(posedge clk);
    #1 cfg_we = 1'b0; cfg_start = 1'b0;
  endtask

  // called just after a reference edge; counts edges until word_ready
  task automatic wait_word(input int n_exp, input string req);
    int edges = 0;
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      if (word_ready) break;
      @(posedge clk);
      edges++;
    end
    check(edges == n_exp && word_ready, req, "edges to word_ready", edges, n_exp);
  endtask

  task automatic host_read(input bit last);
    @(negedge clk);
    data_rd = 1'b1;
    @(posedge clk);
    #1 data_rd = 1'b0;
    #1;
    check(!word_ready, "R7", "word_ready after read", word_ready, 0);
    check(busy == !last, "R7", "busy after read", busy, !last);
  endtask

  task automatic run_xfer(input logic [31:0] a, input logic [2:0] code, input bit slow,
                          input bit own, input logic [3:0] dly, input bit ien,
                          input bit de, input bit rep);
    int words = (code == 3'd7) ? 1 : (1 << code);
    int c = cost_of(slow, own);
    logic [31:0] ea = eff_of(a);
    load_cmd(8'hB7, a);
    owner_sec = own; dma_en = de; dma_repeat = rep;
    kick(code, slow, dly, ien, 1'b1);
    for (int w = 0; w < words; w++) begin
      bit last = (w == words - 1);
      if (w == 0) wait_word((int'(dly) + 12) * c, "R4");
      else        wait_word(4 * c, "R5");
      check(data_out == ((ea + 32'(4*w)) ^ SALT), "R6", "word data",
            data_out, (ea + 32'(4*w)) ^ SALT);
      check(dma_req == de, "R8", "dma_req", dma_req, de);
      check(irq == (last && ien), "R9", "irq", irq, last && ien);
      check(dma_off == (last && de && !rep), "R9", "dma_off", dma_off, last && de && !rep);
      host_read(last);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    #2;
    // R13 reset state
    check(!busy && !word_ready, "R13", "busy/ready after reset", {busy, word_ready}, 0);
    check(!dma_req && !dma_off && !irq, "R13", "pulses after reset", {dma_req, dma_off, irq}, 0);
    check(data_out == 0, "R13", "data_out after reset", data_out, 0);

    // R1 R3 R6 R8 R9: every block code with mixed rate, owner, dma, irq
    for (int code = 1; code <= 7; code++)
      run_xfer(32'h0001_0000 + 32'(code * 32'h1000), 3'(code), code[0], code[1],
               4'(code * 2), code != 3, code != 5, code == 4);

    // R4: first-word latency over all delays, rates and owners
    for (int d = 0; d < 16; d++)
      for (int rs = 0; rs < 4; rs++)
        run_xfer(32'h00A0_0000 + 32'(d * 64 + rs * 16), 3'd7, rs[0], rs[1], 4'(d), 1'b1, 1'b0, 1'b0);

    // R2: low addresses folded above the floor
    run_xfer(32'h0000_1234, 3'd1, 1'b0, 1'b1, 4'd0, 1'b0, 1'b1, 1'b1);
    run_xfer(32'h0000_7FFF, 3'd7, 1'b0, 1'b1, 4'd0, 1'b0, 1'b0, 1'b0);
    run_xfer(32'h0000_8000, 3'd7, 1'b1, 1'b1, 4'd1, 1'b0, 1'b0, 1'b0);
    run_xfer(32'hDEAD_BEE0, 3'd7, 1'b0, 1'b0, 4'd2, 1'b1, 1'b1, 1'b0);

    // R5: word held while host does not read
    begin
      load_cmd(8'hB7, 32'h0002_0000);
      owner_sec = 1'b1; dma_en = 1'b0;
      kick(3'd1, 1'b0, 4'd0, 1'b0, 1'b1);
      wait_word(60, "R5");
      repeat (200) @(posedge clk);
      #2;
      check(word_ready && busy, "R5", "word held without read", {word_ready, busy}, 3);
      check(data_out == (32'h0002_0000 ^ SALT), "R5", "data held", data_out, 32'h0002_0000 ^ SALT);
      host_read(1'b0);
      wait_word(20, "R5");
      host_read(1'b1);
    end

    // R10: chip ID command
    begin
      load_cmd(8'hB8, 32'h0);
      dma_en = 1'b1;
      kick(3'd3, 1'b0, 4'd5, 1'b1, 1'b1);
      #1;
      check(word_ready && busy, "R10", "id ready at start edge", {word_ready, busy}, 3);
      check(data_out == CID, "R10", "id word", data_out, CID);
      check(!dma_req && !irq, "R10", "no dma/irq for id", {dma_req, irq}, 0);
      host_read(1'b1);
      dma_en = 1'b0;
    end

    // R11: unknown opcode and zero block code
    begin
      load_cmd(8'h9F, 32'h0003_0000);
      kick(3'd2, 1'b0, 4'd0, 1'b1, 1'b1);
      #1;
      check(!busy && !word_ready, "R11", "unknown opcode idle", {busy, word_ready}, 0);
      load_cmd(8'hB7, 32'h0003_0000);
      kick(3'd0, 1'b0, 4'd0, 1'b1, 1'b1);
      #1;
      check(!busy && !word_ready, "R11", "code 0 idle", {busy, word_ready}, 0);
      repeat (300) @(posedge clk);
      #2;
      check(!word_ready && !irq, "R11", "no word after code 0", {word_ready, irq}, 0);
    end

    // R12: restart landing on the completion edge of the pending word
    begin
      load_cmd(8'hB7, 32'h0004_0000);
      owner_sec = 1'b1; dma_en = 1'b1; dma_repeat = 1'b0;
      kick(3'd7, 1'b0, 4'd3, 1'b0, 1'b1);
      repeat ((3 + 12) * 5 - 1) @(posedge clk);
      #1;
      cfg_we = 1'b1; cfg_start = 1'b1; cfg_blk = 3'd7; cfg_slow = 1'b1;
      cfg_dly = 4'd1; cfg_irq_en = 1'b1;
      @(posedge clk);
      #1 cfg_we = 1'b0; cfg_start = 1'b0;
      #1;
      check(!word_ready && !dma_req, "R12", "suppressed word at collision",
            {word_ready, dma_req}, 0);
      check(busy, "R12", "busy across restart", busy, 1);
      wait_word((1 + 12) * 8 - 0, "R12");
      check(irq && dma_off && dma_req, "R12", "pulses of restarted block",
            {irq, dma_off, dma_req}, 3'b111);
      host_read(1'b1);
      // R12 restart in the middle of a wait
      kick(3'd7, 1'b0, 4'd0, 1'b0, 1'b0);
      repeat (20) @(posedge clk);
      #1;
      kick(3'd7, 1'b0, 4'd2, 1'b0, 1'b1);
      wait_word(70, "R12");
      host_read(1'b1);
      dma_en = 1'b0;
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule